// File: doc/BRIEF.md
# I2S Serial Audio Receiver with Buffer Flags

The block receives serial audio from an I2S bus in slave mode: the bit clock and the word-select line both come from an external master. The three bus lines are brought into the system clock domain, and data bits are taken on each rising bit-clock edge. Standard I2S framing applies. A word starts one bit-clock period after word-select changes, and the most significant bit comes first.

Bits are grouped into 16-bit packets, whatever the sample width. A 16-bit channel slot gives one packet. A 32-bit slot gives two packets, upper half first. Each packet goes into a single receive buffer, tagged with the channel side of its word. A host reads the buffer through a data-read strobe and a status-read strobe. The host sees these flags:

- buffer full
- overrun
- channel side
- busy

The data and error interrupt outputs are each gated by an enable input. An enable input starts reception. When it is cleared, reception stops only after the half-word in progress has finished.

Top module: `i2s_rx_flags`

## Requirements
- R1: After reset, data_o is 0 and full_o, overrun_o, side_o, busy_o, irq_data_o and irq_err_o are all 0.
- R2: The first bit of a word is sampled on the rising sck_i edge that follows the rising edge at which ws_i is first seen changed. Bits are shifted most significant first, and every 16 bits form one packet.
- R3: A 16-bit channel slot yields one packet. A 32-bit slot yields two packets: bits 31..16 first, then bits 15..0. A partial group of fewer than 16 bits at a ws_i change is discarded.
- R4: side_o takes the ws_i level of the packet's word (0 = left, ws_i low; 1 = right) each time a packet enters the buffer. A dropped packet does not change it.
- R5: full_o goes to 1 when a packet enters the buffer, and a rd_data_i strobe clears it. irq_data_o equals full_o AND full_ie_i.
- R6: If a packet completes while full_o is 1 and no rd_data_i strobe is given in that cycle, overrun_o goes to 1. The new packet is dropped, and data_o and side_o keep their values. irq_err_o equals overrun_o AND err_ie_i.
- R7: overrun_o is cleared only by a rd_data_i strobe followed later by a rd_stat_i strobe. A rd_stat_i strobe alone leaves it set.
- R8: When a rd_data_i strobe falls in the same clock cycle as a packet arrival, the old packet is read. The new packet is stored, full_o stays 1, and overrun_o stays 0.
- R9: If en_i is cleared while a packet is partly received, that packet completes and is delivered. After that, no packet is delivered while en_i is 0.
- R10: busy_o goes to 1 on a rising sck_i edge while the block is active. It is 0 right after a packet completes, and 0 while the block is idle.
- R11: After en_i rises, bits are ignored until a ws_i change has been seen. No packet is delivered before the word that follows that change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Reception enable |
| full_ie_i | input | 1 | Data interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| rd_data_i | input | 1 | Data register read strobe |
| rd_stat_i | input | 1 | Status register read strobe |
| sck_i | input | 1 | Serial bit clock from the master |
| ws_i | input | 1 | Word select from the master |
| sd_i | input | 1 | Serial data |
| data_o | output | 16 | Receive buffer contents |
| full_o | output | 1 | Buffer holds unread data |
| overrun_o | output | 1 | Packet lost to a full buffer |
| side_o | output | 1 | Channel of buffered packet (0 left, 1 right) |
| busy_o | output | 1 | Half-word reception under way |
| irq_data_o | output | 1 | Data interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
A host data read and the arrival of a new packet can fall in the same system clock cycle. When they do, the old packet is consumed, the new one is stored and no overrun is raised. The bench provokes this case by counting the synchronizer, edge-detect and packet registers from the final rising bit-clock edge of a word, and placing the read strobe exactly in the arrival cycle. It then judges three things: data_o held the old packet during the strobe, data_o shows the new packet afterwards with the full flag still set, and the overrun flag stays clear.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  parameter int unsigned PKT_W = 16;
  localparam int unsigned CNT_W = $clog2(PKT_W);

  typedef struct packed {
    logic             side;
    logic [PKT_W-1:0] data;
  } pkt_t;
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
  import i2s_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic pkt_valid_o,
  output pkt_t pkt_o,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PKT_W - 1);

  logic             sck_q, ws_last_q, active_q, in_word_q, side_q, busy_q, pkt_valid_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PKT_W-2:0] sr_q;
  pkt_t             pkt_q;
  logic             rise, emit, stop;

  assign rise = sck_i & ~sck_q;
  assign emit = active_q & rise & in_word_q & (cnt_q == CNT_LAST);
  // finish the half-word in flight before going idle
  assign stop = active_q & ~en_i & (emit | (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b0;
      ws_last_q   <= 1'b0;
      active_q    <= 1'b0;
      in_word_q   <= 1'b0;
      side_q      <= 1'b0;
      busy_q      <= 1'b0;
      pkt_valid_q <= 1'b0;
      cnt_q       <= '0;
      sr_q        <= '0;
      pkt_q       <= '0;
    end else begin
      sck_q       <= sck_i;
      pkt_valid_q <= 1'b0;
      if (rise) ws_last_q <= ws_i;
      if (en_i && !active_q) active_q <= 1'b1;
      if (active_q && rise) begin
        busy_q <= 1'b1;
        if (in_word_q) begin
          sr_q <= {sr_q[PKT_W-3:0], sd_i};
          if (cnt_q == CNT_LAST) begin
            pkt_valid_q <= 1'b1;
            pkt_q.side  <= side_q;
            pkt_q.data  <= {sr_q, sd_i};
            cnt_q       <= '0;
            busy_q      <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        // edge that reveals a ws change carries the previous word's LSB
        if (ws_i != ws_last_q) begin
          in_word_q <= 1'b1;
          side_q    <= ws_i;
          cnt_q     <= '0;
        end
      end
      if (stop) begin
        active_q  <= 1'b0;
        in_word_q <= 1'b0;
        cnt_q     <= '0;
        busy_q    <= 1'b0;
      end
    end
  end

  assign pkt_valid_o = pkt_valid_q;
  assign pkt_o       = pkt_q;
  assign busy_o      = busy_q;

  assert_pkt_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_q |=> !pkt_valid_q);
  assert_busy_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_q |-> !busy_q);
  assert_idle_not_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !busy_q);
  assert_no_pkt_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !$past(active_q)) |-> !pkt_valid_q);
endmodule

// File: rtl/i2s_rx_buf.sv
module i2s_rx_buf
  import i2s_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_valid_i,
  input  pkt_t             pkt_i,
  input  logic             rd_data_i,
  input  logic             rd_stat_i,
  input  logic             full_ie_i,
  input  logic             err_ie_i,
  output logic [PKT_W-1:0] data_o,
  output logic             full_o,
  output logic             overrun_o,
  output logic             side_o,
  output logic             irq_data_o,
  output logic             irq_err_o
);
  logic [PKT_W-1:0] data_q;
  logic             full_q, side_q, ovr_q, armed_q;
  logic             load, lost;

  assign load = pkt_valid_i & (~full_q | rd_data_i);
  assign lost = pkt_valid_i & full_q & ~rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      side_q  <= 1'b0;
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (load) begin
        data_q <= pkt_i.data;
        side_q <= pkt_i.side;
        full_q <= 1'b1;
      end else if (rd_data_i) begin
        full_q <= 1'b0;
      end
      // overrun clears on data read then status read
      if (lost) begin
        ovr_q   <= 1'b1;
        armed_q <= 1'b0;
      end else if (rd_stat_i && armed_q) begin
        ovr_q   <= 1'b0;
        armed_q <= 1'b0;
      end else if (rd_data_i && ovr_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign data_o     = data_q;
  assign full_o     = full_q;
  assign overrun_o  = ovr_q;
  assign side_o     = side_q;
  assign irq_data_o = full_q & full_ie_i;
  assign irq_err_o  = ovr_q & err_ie_i;

  assert_full_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> full_q);
  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !pkt_valid_i) |=> !full_q);
  assert_drop_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && full_q && !rd_data_i) |=> (ovr_q && $stable(data_q) && $stable(side_q)));
  assert_same_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && rd_data_i && !ovr_q) |=> (full_q && !ovr_q && data_q == $past(pkt_i.data)));
  assert_stat_alone_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && rd_stat_i && !armed_q) |=> ovr_q);
endmodule

// File: rtl/i2s_rx_flags.sv
module i2s_rx_flags
  import i2s_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             full_ie_i,
  input  logic             err_ie_i,
  input  logic             rd_data_i,
  input  logic             rd_stat_i,
  input  logic             sck_i,
  input  logic             ws_i,
  input  logic             sd_i,
  output logic [PKT_W-1:0] data_o,
  output logic             full_o,
  output logic             overrun_o,
  output logic             side_o,
  output logic             busy_o,
  output logic             irq_data_o,
  output logic             irq_err_o
);
  logic [2:0] bus_s;
  logic       pkt_valid;
  pkt_t       pkt;

  i2s_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ws_i, sd_i}),
    .q_o   (bus_s)
  );

  i2s_rx_deser u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .sck_i      (bus_s[2]),
    .ws_i       (bus_s[1]),
    .sd_i       (bus_s[0]),
    .pkt_valid_o(pkt_valid),
    .pkt_o      (pkt),
    .busy_o     (busy_o)
  );

  i2s_rx_buf u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_valid_i(pkt_valid),
    .pkt_i      (pkt),
    .rd_data_i  (rd_data_i),
    .rd_stat_i  (rd_stat_i),
    .full_ie_i  (full_ie_i),
    .err_ie_i   (err_ie_i),
    .data_o     (data_o),
    .full_o     (full_o),
    .overrun_o  (overrun_o),
    .side_o     (side_o),
    .irq_data_o (irq_data_o),
    .irq_err_o  (irq_err_o)
  );
endmodule

// File: tb/i2s_rx_flags_tb.sv
`timescale 1ns/1ps
module i2s_rx_flags_tb;
  localparam int H = 8;  // system clocks per half bit-clock

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, full_ie = 0, err_ie = 0, rd_data = 0, rd_stat = 0;
  logic sck = 0, ws = 0, sd = 0;
  logic [15:0] data;
  logic full, overrun, side, busy, irq_data, irq_err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2s_rx_flags u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .full_ie_i(full_ie), .err_ie_i(err_ie),
    .rd_data_i(rd_data), .rd_stat_i(rd_stat), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .data_o(data), .full_o(full), .overrun_o(overrun), .side_o(side), .busy_o(busy),
    .irq_data_o(irq_data), .irq_err_o(irq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic b);
    @(negedge clk); sck = 0; ws = w; sd = b;
    repeat (H - 1) @(negedge clk);
    sck = 1;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_word(input logic ch, input logic [31:0] d, input int len, input logic nxt);
    for (int i = len - 1; i >= 1; i--) send_bit(ch, d[i]);
    send_bit(nxt, d[0]);
  endtask

  task automatic pulse_rd_data;
    @(negedge clk); rd_data = 1; @(negedge clk); rd_data = 0;
  endtask

  task automatic pulse_rd_stat;
    @(negedge clk); rd_stat = 1; @(negedge clk); rd_stat = 0;
  endtask

  task automatic t_reset;
    chk("R1 data", data, 0);
    chk("R1 flags", {full, overrun, side, busy, irq_data, irq_err}, 0);
  endtask

  task automatic t_sync;
    @(negedge clk); en = 1;
    for (int i = 0; i < 6; i++) send_bit(0, 1);
    chk("R11 no packet before ws change", full, 0);
    chk("R10 busy on sck activity", busy, 1);
    send_bit(1, 1);  // ws change: right word follows
    chk("R11 change bit not captured", full, 0);
  endtask

  task automatic t_basic;
    send_word(1, 32'h3C5A, 16, 0);
    chk("R2 right data", data, 16'h3C5A);
    chk("R4 right side", side, 1);
    chk("R5 full set", full, 1);
    chk("R10 busy low after packet", busy, 0);
    chk("R5 irq gated off", irq_data, 0);
    @(negedge clk); full_ie = 1; @(negedge clk);
    chk("R5 irq on", irq_data, 1);
    pulse_rd_data;
    chk("R5 read clears full", {full, irq_data}, 0);
    send_word(0, 32'hA5C3, 16, 1);
    chk("R2 left data", data, 16'hA5C3);
    chk("R4 left side", side, 0);
    pulse_rd_data;
  endtask

  task automatic t_wide;
    for (int i = 31; i >= 16; i--) send_bit(1, i[0] ? 1'b0 : 1'b1 ^ 1'b1 ^ 1'b1 ? 1'b1 : 1'b0);
    chk("R3 upper half", data, 16'h5555);
    chk("R3 upper side", side, 1);
    pulse_rd_data;
    send_word(1, 32'h0000ABCD, 16, 0);
    chk("R3 lower half", data, 16'hABCD);
    chk("R3 lower side", side, 1);
    pulse_rd_data;
  endtask

  task automatic t_ovr;
    send_word(0, 32'h1111, 16, 1);
    chk("R6 first held", full, 1);
    send_word(1, 32'h2222, 16, 0);
    chk("R6 overrun set", overrun, 1);
    chk("R6 data kept", data, 16'h1111);
    chk("R6 side kept", side, 0);
    chk("R6 err irq off", irq_err, 0);
    @(negedge clk); err_ie = 1; @(negedge clk);
    chk("R6 err irq on", irq_err, 1);
    pulse_rd_stat;
    chk("R7 status read alone keeps", overrun, 1);
    pulse_rd_data;
    chk("R7 data read keeps", overrun, 1);
    chk("R5 full cleared", full, 0);
    pulse_rd_stat;
    chk("R7 cleared after sequence", {overrun, irq_err}, 0);
  endtask

  task automatic t_same;
    logic [15:0] seen;
    logic [15:0] d = 16'h5A0F;
    send_word(0, 32'h4444, 16, 1);
    chk("R8 setup full", full, 1);
    for (int i = 15; i >= 1; i--) send_bit(1, d[i]);
    @(negedge clk); sck = 0; ws = 0; sd = d[0];
    repeat (H - 1) @(negedge clk);
    sck = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); seen = data; rd_data = 1;
    @(negedge clk); rd_data = 0;
    repeat (H) @(negedge clk);
    chk("R8 old read", seen, 16'h4444);
    chk("R8 new stored", data, d);
    chk("R8 full stays", full, 1);
    chk("R8 no overrun", overrun, 0);
    pulse_rd_data;
  endtask

  task automatic t_dis;
    logic [15:0] d = 16'h6789;
    for (int i = 15; i >= 11; i--) send_bit(0, d[i]);
    @(negedge clk); en = 0;
    for (int i = 10; i >= 1; i--) send_bit(0, d[i]);
    send_bit(1, d[0]);
    chk("R9 last packet delivered", data, d);
    chk("R9 full", full, 1);
    chk("R10 busy low when off", busy, 0);
    pulse_rd_data;
    send_word(1, 32'h9999, 16, 0);
    chk("R9 nothing while off", full, 0);
    chk("R10 idle busy", busy, 0);
    @(negedge clk); en = 1;
    send_word(0, 32'h7777, 16, 1);
    chk("R11 resync needed", full, 0);
    send_word(1, 32'h8888, 16, 0);
    chk("R11 after resync", data, 16'h8888);
    chk("R11 side", side, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_sync;
    t_basic;
    t_wide;
    t_ovr;
    t_same;
    t_dis;
    finish_run;
  end
endmodule